// File: doc/BRIEF.md
# Segment Descriptor Cache Register

This block models one segment register of a segmented-address processor together with the descriptor information it keeps out of view. It holds four parts: a 16-bit selector that software sees, a 32-bit base, a 32-bit limit and a 4-bit permission field. All four parts are in use in every mode. What changes with the mode is how a load fills them and how a code-segment register's permissions are read.

A two-state machine holds the operating mode. The states are `ST_REAL` and `ST_PROT`. Transition `ENTER_PROT` goes from `ST_REAL` to `ST_PROT` when `prot_mode_i` is high at a clock edge. Transition `LEAVE_PROT` goes back when `prot_mode_i` is low. In any other case the state holds.

A load in real mode writes only the selector and the base, so a limit set in protected mode stays in force after the switch back to real mode. This allows a 4 GiB reach from real mode. A load in protected mode takes base, limit and flags from a descriptor that surrounding logic has already fetched. A combinational check port turns an offset and an access kind into a linear address and a fault flag. The parameter `IS_CODE_REG` selects the code-segment variant, which carries the special write rules.

Top module: `seg_desc_cache`

## Requirements
- R1: A synchronous active-high `rst` sets selector 0, base 0, limit 0x0000FFFF, flags 0xD and state `ST_REAL`.
- R2: The mode state takes the value of `prot_mode_i` at each clock edge, and `mode_prot_o` shows it. A load in the same cycle is interpreted in the mode held before that edge.
- R3: A load in `ST_REAL` sets the selector to `ld_sel_i` and the base to `ld_sel_i` shifted left by 4, zero-extended to 32 bits.
- R4: A load in `ST_REAL` leaves the limit and the flags unchanged.
- R5: A load in `ST_PROT` sets the selector to `ld_sel_i` and the base, limit and flags to `ld_base_i`, `ld_limit_i` and `ld_flags_i`.
- R6: A limit of 0xFFFFFFFF loaded in `ST_PROT` stays in force through `LEAVE_PROT` and later real-mode loads. A limit of 0x0000FFFF is restored the same way.
- R7: `fault_o` is high whenever `chk_off_i` is greater than the limit. `lin_addr_o` is always base plus `chk_off_i` modulo 2^32.
- R8: With `IS_CODE_REG`=1, a write (kind 1) in `ST_PROT` always faults, whatever the flags.
- R9: With `IS_CODE_REG`=1 in `ST_REAL`, writes are allowed whatever the flags. A read (kind 0) of a code segment whose readable bit is clear faults.
- R10: With `IS_CODE_REG`=0, a write faults in both modes if the flags mark a code segment or have the writable bit clear. Reads of a data segment do not fault.
- R11: Flags bits: [0] present, [1] code, [2] readable, [3] writable. Any access with present clear faults. Execute (kind 2) in `ST_PROT` faults unless code is set. Kind 3 always faults.
- R12: With `ld_valid_i` low, the selector, base, limit and flags hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| prot_mode_i | input | 1 | Requested mode, 1 = protected |
| ld_valid_i | input | 1 | Load strobe |
| ld_sel_i | input | 16 | New selector |
| ld_base_i | input | 32 | Descriptor base (used in protected mode) |
| ld_limit_i | input | 32 | Descriptor limit (used in protected mode) |
| ld_flags_i | input | 4 | Descriptor flags (used in protected mode) |
| chk_off_i | input | 32 | Offset to check |
| chk_kind_i | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| sel_o | output | 16 | Current selector |
| base_o | output | 32 | Current base |
| limit_o | output | 32 | Current limit |
| flags_o | output | 4 | Current flags |
| mode_prot_o | output | 1 | 1 when the state is `ST_PROT` |
| lin_addr_o | output | 32 | Base plus offset |
| fault_o | output | 1 | Access check failed |

## Verification
The assertions check, on every cycle, the rules that hold cycle by cycle. These are the reset values, the state following the mode input, the effect of real-mode and protected-mode loads on each field, faults on offsets past the limit, and a protected-mode write on the code register always faulting. Some behaviours only the bench's scenarios can show, because they span several loads and mode switches. These are the big-limit carry-over into real mode, the return to a 64 KiB limit, the execute-only read and write quirk, and the different permissions of the code and data variants for the same flags.

// File: rtl/seg_pkg.sv
package seg_pkg;
    typedef enum logic {
        ST_REAL = 1'b0,
        ST_PROT = 1'b1
    } seg_mode_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } seg_acc_e;

    localparam int FLG_W     = 4;
    localparam int FLG_PRES  = 0;
    localparam int FLG_CODE  = 1;
    localparam int FLG_READ  = 2;
    localparam int FLG_WRITE = 3;
    localparam logic [FLG_W-1:0] FLG_RESET = 4'hD;
endpackage

// File: rtl/seg_mode_fsm.sv
module seg_mode_fsm
    import seg_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic prot_req,
    output logic in_prot
);
    seg_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_REAL: if (prot_req)  state_d = ST_PROT;  // ENTER_PROT
            ST_PROT: if (!prot_req) state_d = ST_REAL;  // LEAVE_PROT
            default: state_d = ST_REAL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_REAL;
        else     state_q <= state_d;
    end

    always_comb in_prot = (state_q == ST_PROT);

    p_mode_follow_r2: assert property (@(posedge clk) disable iff (rst)
        !rst |=> in_prot == $past(prot_req));
endmodule

// File: rtl/seg_cache_regs.sv
module seg_cache_regs
    import seg_pkg::*;
#(
    parameter int SEL_W   = 16,
    parameter int ADDR_W  = 32,
    parameter int SHIFT   = 4,
    parameter logic [ADDR_W-1:0] RST_LIMIT = 32'h0000_FFFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_prot,
    input  logic              ld_valid,
    input  logic [SEL_W-1:0]  ld_sel,
    input  logic [ADDR_W-1:0] ld_base,
    input  logic [ADDR_W-1:0] ld_limit,
    input  logic [FLG_W-1:0]  ld_flags,
    output logic [SEL_W-1:0]  sel_q,
    output logic [ADDR_W-1:0] base_q,
    output logic [ADDR_W-1:0] limit_q,
    output logic [FLG_W-1:0]  flags_q
);
    localparam int PAD_W = ADDR_W - SEL_W - SHIFT;

    logic [ADDR_W-1:0] real_base;
    always_comb real_base = {{PAD_W{1'b0}}, ld_sel, {SHIFT{1'b0}}};

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q   <= '0;
            base_q  <= '0;
            limit_q <= RST_LIMIT;
            flags_q <= FLG_RESET;
        end else if (ld_valid) begin
            sel_q <= ld_sel;
            if (in_prot) begin
                base_q  <= ld_base;
                limit_q <= ld_limit;
                flags_q <= ld_flags;
            end else begin
                base_q  <= real_base;
            end
        end
    end

    p_reset_vals_r1: assert property (@(posedge clk)
        rst |=> (sel_q == '0 && base_q == '0 && limit_q == RST_LIMIT && flags_q == FLG_RESET));
    p_real_base_r3: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !in_prot) |=> (sel_q == $past(ld_sel)) &&
            (base_q == ({{PAD_W{1'b0}}, $past(ld_sel)} << SHIFT)));
    p_real_keep_r4: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && !in_prot) |=> ($stable(limit_q) && $stable(flags_q)));
    p_prot_load_r5: assert property (@(posedge clk) disable iff (rst)
        (ld_valid && in_prot) |=> (base_q == $past(ld_base) && limit_q == $past(ld_limit) &&
            flags_q == $past(ld_flags) && sel_q == $past(ld_sel)));
    p_hold_r12: assert property (@(posedge clk) disable iff (rst)
        !ld_valid |=> ($stable(sel_q) && $stable(base_q) && $stable(limit_q) && $stable(flags_q)));
endmodule

// File: rtl/seg_access_chk.sv
module seg_access_chk
    import seg_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter bit IS_CODE_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_prot,
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] limit,
    input  logic [FLG_W-1:0]  flags,
    input  logic [ADDR_W-1:0] off,
    input  logic [1:0]        kind,
    output logic [ADDR_W-1:0] lin_addr,
    output logic              fault
);
    logic over_limit, perm_bad, write_bad;
    logic is_code, readable, writable, present;

    always_comb begin
        is_code  = flags[FLG_CODE];
        readable = flags[FLG_READ];
        writable = flags[FLG_WRITE];
        present  = flags[FLG_PRES];
    end

    generate
        if (IS_CODE_REG) begin : g_code_reg
            // protected: never writable; real: always writable
            always_comb write_bad = in_prot;
        end else begin : g_data_reg
            always_comb write_bad = is_code || !writable;
        end
    endgenerate

    always_comb begin
        perm_bad = 1'b0;
        unique case (seg_acc_e'(kind))
            ACC_READ:  perm_bad = is_code && !readable;
            ACC_WRITE: perm_bad = write_bad;
            ACC_EXEC:  perm_bad = in_prot && !is_code;
            ACC_RSVD:  perm_bad = 1'b1;
            default:   perm_bad = 1'b1;
        endcase
    end

    always_comb begin
        over_limit = off > limit;
        lin_addr   = base + off;
        fault      = over_limit || perm_bad || !present;
    end

    p_limit_fault_r7: assert property (@(posedge clk) disable iff (rst)
        (off > limit) |-> fault);
    p_rsvd_fault_r11: assert property (@(posedge clk) disable iff (rst)
        (kind == 2'd3) |-> fault);
    generate
        if (IS_CODE_REG) begin : g_cs_assert
            p_cs_nowrite_r8: assert property (@(posedge clk) disable iff (rst)
                (in_prot && kind == 2'd1) |-> fault);
        end
    endgenerate
endmodule

// File: rtl/seg_desc_cache.sv
module seg_desc_cache
    import seg_pkg::*;
#(
    parameter int SEL_W       = 16,
    parameter int ADDR_W      = 32,
    parameter int SHIFT       = 4,
    parameter bit IS_CODE_REG = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              prot_mode_i,
    input  logic              ld_valid_i,
    input  logic [SEL_W-1:0]  ld_sel_i,
    input  logic [ADDR_W-1:0] ld_base_i,
    input  logic [ADDR_W-1:0] ld_limit_i,
    input  logic [3:0]        ld_flags_i,
    input  logic [ADDR_W-1:0] chk_off_i,
    input  logic [1:0]        chk_kind_i,
    output logic [SEL_W-1:0]  sel_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] limit_o,
    output logic [3:0]        flags_o,
    output logic              mode_prot_o,
    output logic [ADDR_W-1:0] lin_addr_o,
    output logic              fault_o
);
    localparam logic [ADDR_W-1:0] RST_LIMIT = ADDR_W'((64'd1 << (SEL_W)) - 64'd1);

    logic in_prot;

    seg_mode_fsm u_fsm (
        .clk      (clk),
        .rst      (rst),
        .prot_req (prot_mode_i),
        .in_prot  (in_prot)
    );

    seg_cache_regs #(
        .SEL_W     (SEL_W),
        .ADDR_W    (ADDR_W),
        .SHIFT     (SHIFT),
        .RST_LIMIT (RST_LIMIT)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .in_prot  (in_prot),
        .ld_valid (ld_valid_i),
        .ld_sel   (ld_sel_i),
        .ld_base  (ld_base_i),
        .ld_limit (ld_limit_i),
        .ld_flags (ld_flags_i),
        .sel_q    (sel_o),
        .base_q   (base_o),
        .limit_q  (limit_o),
        .flags_q  (flags_o)
    );

    seg_access_chk #(
        .ADDR_W      (ADDR_W),
        .IS_CODE_REG (IS_CODE_REG)
    ) u_chk (
        .clk      (clk),
        .rst      (rst),
        .in_prot  (in_prot),
        .base     (base_o),
        .limit    (limit_o),
        .flags    (flags_o),
        .off      (chk_off_i),
        .kind     (chk_kind_i),
        .lin_addr (lin_addr_o),
        .fault    (fault_o)
    );

    always_comb mode_prot_o = in_prot;
endmodule

// File: tb/tb_seg_desc_cache.sv
`timescale 1ns/1ps
module tb_seg_desc_cache;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        prot = 1'b0;
    logic        ldv = 1'b0;
    logic [15:0] lsel = '0;
    logic [31:0] lbase = '0, llim = '0, off = '0;
    logic [3:0]  lflg = '0;
    logic [1:0]  kind = '0;

    logic [15:0] sel_c, sel_d;
    logic [31:0] base_c, base_d, lim_c, lim_d, lin_c, lin_d;
    logic [3:0]  flg_c, flg_d;
    logic        mp_c, mp_d, flt_c, flt_d;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    seg_desc_cache #(.IS_CODE_REG(1'b1)) dut (
        .clk(clk), .rst(rst), .prot_mode_i(prot), .ld_valid_i(ldv), .ld_sel_i(lsel),
        .ld_base_i(lbase), .ld_limit_i(llim), .ld_flags_i(lflg), .chk_off_i(off),
        .chk_kind_i(kind), .sel_o(sel_c), .base_o(base_c), .limit_o(lim_c),
        .flags_o(flg_c), .mode_prot_o(mp_c), .lin_addr_o(lin_c), .fault_o(flt_c));

    seg_desc_cache #(.IS_CODE_REG(1'b0)) dut_ds (
        .clk(clk), .rst(rst), .prot_mode_i(prot), .ld_valid_i(ldv), .ld_sel_i(lsel),
        .ld_base_i(lbase), .ld_limit_i(llim), .ld_flags_i(lflg), .chk_off_i(off),
        .chk_kind_i(kind), .sel_o(sel_d), .base_o(base_d), .limit_o(lim_d),
        .flags_o(flg_d), .mode_prot_o(mp_d), .lin_addr_o(lin_d), .fault_o(flt_d));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_mode(input logic p);
        prot = p;
        tick();
    endtask

    task automatic load(input logic [15:0] s, input logic [31:0] b, input logic [31:0] l,
                        input logic [3:0] f);
        lsel = s; lbase = b; llim = l; lflg = f; ldv = 1'b1;
        tick();
        ldv = 1'b0;
    endtask

    task automatic probe(input logic [31:0] o, input logic [1:0] k);
        off = o; kind = k;
        #1;
    endtask

    task automatic t_reset();
        chk("R1 sel", 32'(sel_c), 32'h0);
        chk("R1 base", base_c, 32'h0);
        chk("R1 limit", lim_c, 32'h0000FFFF);
        chk("R1 flags", 32'(flg_c), 32'hD);
        chk("R1 mode", 32'(mp_c), 32'h0);
    endtask

    task automatic t_real_load();
        load(16'h1234, 32'hDEAD0000, 32'h00000010, 4'h0);
        chk("R3 sel", 32'(sel_c), 32'h1234);
        chk("R3 base", base_c, 32'h00012340);
        chk("R4 limit kept", lim_c, 32'h0000FFFF);
        chk("R4 flags kept", 32'(flg_c), 32'hD);
        probe(32'h10, 2'd0);
        chk("R7 lin", lin_c, 32'h00012350);
        chk("R7 no fault", 32'(flt_c), 32'h0);
        probe(32'h0000FFFF, 2'd0);
        chk("R7 at limit", 32'(flt_c), 32'h0);
        probe(32'h00010000, 2'd0);
        chk("R7 past limit", 32'(flt_c), 32'h1);
    endtask

    task automatic t_mode_edge();
        // R2: load in same cycle as ENTER_PROT is still a real-mode load
        prot = 1'b1;
        load(16'h0040, 32'h11111111, 32'h00001234, 4'h3);
        chk("R2 mode now prot", 32'(mp_c), 32'h1);
        chk("R2 real-load base", base_c, 32'h00000400);
        chk("R2 limit untouched", lim_c, 32'h0000FFFF);
        set_mode(1'b0);
        chk("R2 back to real", 32'(mp_c), 32'h0);
    endtask

    task automatic t_big_real();
        set_mode(1'b1);
        load(16'h0008, 32'h00100000, 32'hFFFFFFFF, 4'hD);
        chk("R5 sel", 32'(sel_c), 32'h0008);
        chk("R5 base", base_c, 32'h00100000);
        chk("R5 limit", lim_c, 32'hFFFFFFFF);
        chk("R5 flags", 32'(flg_c), 32'hD);
        set_mode(1'b0);
        load(16'h2000, 32'h0, 32'h0, 4'h0);
        chk("R6 base", base_c, 32'h00020000);
        chk("R6 big limit kept", lim_c, 32'hFFFFFFFF);
        probe(32'h00123456, 2'd1);
        chk("R6 big reach lin", lin_c, 32'h00143456);
        chk("R6 big reach no fault", 32'(flt_c), 32'h0);
        probe(32'hFFFFFFFF, 2'd0);
        chk("R7 wrap lin", lin_c, 32'h0001FFFF);
        set_mode(1'b1);
        load(16'h0010, 32'h0, 32'h0000FFFF, 4'hD);
        set_mode(1'b0);
        load(16'h0001, 32'h0, 32'h0, 4'h0);
        chk("R6 small limit restored", lim_c, 32'h0000FFFF);
        probe(32'h00010000, 2'd0);
        chk("R6 small limit faults", 32'(flt_c), 32'h1);
    endtask

    task automatic t_code_quirk();
        set_mode(1'b1);
        load(16'h0018, 32'h0, 32'h0000FFFF, 4'h3); // present+code, execute-only
        probe(32'h0, 2'd1);
        chk("R8 prot write faults", 32'(flt_c), 32'h1);
        probe(32'h0, 2'd0);
        chk("R9 prot exec-only read faults", 32'(flt_c), 32'h1);
        probe(32'h0, 2'd2);
        chk("R11 prot exec on code ok", 32'(flt_c), 32'h0);
        set_mode(1'b0);
        probe(32'h0, 2'd1);
        chk("R9 real write allowed", 32'(flt_c), 32'h0);
        chk("R10 data reg code write faults", 32'(flt_d), 32'h1);
        probe(32'h0, 2'd0);
        chk("R9 real exec-only read faults", 32'(flt_c), 32'h1);
        set_mode(1'b1);
        load(16'h0020, 32'h0, 32'h0000FFFF, 4'hD);
        probe(32'h0, 2'd1);
        chk("R8 prot write faults on rw flags", 32'(flt_c), 32'h1);
        chk("R10 data reg rw write ok", 32'(flt_d), 32'h0);
    endtask

    task automatic t_data_ro();
        load(16'h0028, 32'h0, 32'h0000FFFF, 4'h5); // present+readable, not writable
        probe(32'h0, 2'd1);
        chk("R10 prot ro write faults", 32'(flt_d), 32'h1);
        probe(32'h0, 2'd0);
        chk("R10 data read ok", 32'(flt_d), 32'h0);
        probe(32'h0, 2'd2);
        chk("R11 prot exec on data faults", 32'(flt_d), 32'h1);
        set_mode(1'b0);
        probe(32'h0, 2'd1);
        chk("R10 real ro write faults", 32'(flt_d), 32'h1);
        chk("R9 code reg real write ok", 32'(flt_c), 32'h0);
        probe(32'h0, 2'd3);
        chk("R11 reserved kind faults", 32'(flt_c), 32'h1);
    endtask

    task automatic t_misc();
        set_mode(1'b1);
        load(16'h0030, 32'h0, 32'h0000FFFF, 4'hC); // not present
        probe(32'h0, 2'd0);
        chk("R11 not present faults", 32'(flt_d), 32'h1);
        lsel = 16'hBEEF; lbase = 32'h55555555; llim = 32'h7; lflg = 4'hF; ldv = 1'b0;
        tick();
        chk("R12 sel holds", 32'(sel_c), 32'h0030);
        chk("R12 limit holds", lim_c, 32'h0000FFFF);
        chk("R12 flags hold", 32'(flg_c), 32'hC);
        set_mode(1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_real_load();
        t_mode_edge();
        t_big_real();
        t_code_quirk();
        t_data_ro();
        t_misc();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule